// File: doc/BRIEF.md
# Dual-Limit Alternating Interval Timer

A 16-bit up-counting interval timer with two programmable terminal counts, A and B. In alternating mode the counter climbs to limit A, returns to zero, climbs to limit B, returns to zero, and repeats. A level output reports which limit is in force. Software can therefore set the high and low times of a waveform independently and get any duty cycle. In single mode only limit A is used and the timer is a plain periodic interval source.

Each time the count meets the active limit on a counting step, the timer issues a one-clock interrupt request. A limit of zero means a full 65536-step period. Counting is gated by an enable input. An optional built-in clock divider restricts steps to one clock in every `PRESC_DIV`. The limits are loaded through a simple write port and have no reset value, so they must be written before counting is enabled. The current count is visible at all times.

Top module: `alt_interval_timer`

## Requirements
- R1: After reset the count is 0, `phase_o` is 0 (limit A active) and `irq_o` is 0.
- R2: A step cycle is a cycle with `step_i` high and, when `div_sel_i` is 1, a divider tick. The count rises by one on each step cycle and holds on all other cycles.
- R3: On a step cycle where the count equals the active limit, the count becomes 0 at that edge and `irq_o` is high for exactly the one following cycle.
- R4: With `dual_mode_i` = 1, the active limit starts at A after reset and alternates A, B, A, B. `phase_o` is 0 while A is active and 1 while B is active. An A phase lasts A+1 steps and a B phase lasts B+1 steps.
- R5: With `dual_mode_i` = 0, only limit A is used, `phase_o` stays 0, and every period is A+1 steps.
- R6: A limit of 0 gives a 65536-step period. The count passes through FFFFh, and the match is taken at FFFFh.
- R7: With `wr_en_i` high, `wr_data_i` is stored into limit A when `wr_sel_i` = 0 or limit B when `wr_sel_i` = 1, at the clock edge. The new value is used at the next comparison. A value below the current count makes the counter run through FFFFh and wrap to 0 before it matches.
- R8: With `div_sel_i` = 1, steps occur on at most one clock in every `PRESC_DIV` (default 4). With `step_i` held high the period is (A+1)*4 clocks, so a zero limit gives 262144 clocks, which is 6.5536 ms at 40 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Limit register write strobe |
| wr_sel_i | input | 1 | Limit select: 0 = A, 1 = B |
| wr_data_i | input | 16 | Limit value to store |
| dual_mode_i | input | 1 | 1 = alternate A/B, 0 = A only |
| div_sel_i | input | 1 | 1 = gate steps with the internal divider |
| step_i | input | 1 | Count enable |
| count_o | output | 16 | Current count |
| phase_o | output | 1 | Active limit: 0 = A, 1 = B |
| irq_o | output | 1 | One-cycle interrupt request at each limit match |

## Verification
The assertions assume that both limits hold written values before `step_i` first rises. Without that the match comparison is undefined. They also assume that `div_sel_i` stays steady while counting, because the divider gap check is only meaningful across consecutive cycles in one mode. The bench meets both conditions. After every reset it writes A and B with `step_i` low, and it changes `dual_mode_i` and `div_sel_i` only while reset is asserted. Limit writes during a run happen only while `step_i` is held low.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/timer_cmp_bank.sv
module timer_cmp_bank
  import timer_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned NLIM = 2
) (
  input  logic         clk_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         dual_i,
  input  phase_e       phase_i,
  input  logic [W-1:0] count_i,
  output logic         hit_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [NLIM-1:0][W-1:0] lim_q;
  logic [W-1:0]           lim_act;

  // limits have no defined reset value
  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_sel_i == 1'(i))) lim_q[i] <= wr_data_i;
    end
  end

  assign lim_act = (dual_i && phase_i == PH_B) ? lim_q[1] : lim_q[0];
  // zero limit means full-range period
  assign hit_o   = (lim_act == '0) ? (count_i == TOP) : (count_i == lim_act);
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         hit_i,
  input  logic         dual_i,
  output logic [W-1:0] count_o,
  output phase_e       phase_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      phase_o <= PH_A;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= step_i & hit_i;
      if (step_i) begin
        if (hit_i) begin
          count_o <= '0;
          phase_o <= (dual_i && phase_o == PH_A) ? PH_B : PH_A;
        end else begin
          count_o <= count_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/alt_interval_timer.sv
module alt_interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             dual_mode_i,
  input  logic             div_sel_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             phase_o,
  output logic             irq_o
);
  logic   tick_w;
  logic   step_w;
  logic   hit_w;
  phase_e phase_w;

  timer_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  assign step_w = step_i & (div_sel_i ? tick_w : 1'b1);

  timer_cmp_bank #(.W(CNT_W), .NLIM(2)) u_cmp (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .dual_i   (dual_mode_i),
    .phase_i  (phase_w),
    .count_i  (count_o),
    .hit_o    (hit_w)
  );

  timer_core #(.W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_w),
    .hit_i  (hit_w),
    .dual_i (dual_mode_i),
    .count_o(count_o),
    .phase_o(phase_w),
    .irq_o  (irq_o)
  );

  assign phase_o = phase_w;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         step_i,
  input logic         hit_i,
  input logic         dual_i,
  input logic         div_sel_i,
  input logic [W-1:0] count_i,
  input logic         phase_i,
  input logic         irq_i
);
  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |=> (count_i == '0 && !phase_i && !irq_i)); // R1

  AST_COUNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !hit_i) |=> count_i == $past(count_i) + 1'b1); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(count_i)); // R2

  AST_HIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && hit_i) |=> (count_i == '0 && irq_i)); // R3

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R3

  AST_PHASE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_i && step_i && hit_i) |=> phase_i != $past(phase_i)); // R4

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && hit_i) |=> $stable(phase_i)); // R4

  AST_SINGLE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_i && step_i && hit_i) |=> !phase_i); // R5

  AST_DIV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i && step_i) |=> (!step_i || !div_sel_i)); // R8
endmodule

bind alt_interval_timer timer_chk #(.W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .step_i   (step_w),
  .hit_i    (hit_w),
  .dual_i   (dual_mode_i),
  .div_sel_i(div_sel_i),
  .count_i  (count_o),
  .phase_i  (phase_o),
  .irq_i    (irq_o)
);

// File: tb/alt_interval_timer_tb.sv
module alt_interval_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        dual_mode_i = 1'b0;
  logic        div_sel_i = 1'b0;
  logic        step_i = 1'b0;
  logic [15:0] count_o;
  logic        phase_o;
  logic        irq_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;

  always #5 clk_i = ~clk_i;

  alt_interval_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .dual_mode_i(dual_mode_i), .div_sel_i(div_sel_i),
    .step_i(step_i), .count_o(count_o), .phase_o(phase_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        dual;
    logic [15:0] lim_a;
    logic [15:0] lim_b;
    logic [31:0] len1;
    logic [31:0] len2;
    logic        ph1;
    logic        ph2;
  } vec_t;

  // len1/len2: samples to first/second irq; ph1/ph2: phase_o at those irqs
  localparam vec_t VEC [4] = '{
    '{1'b1, 16'd3,  16'd5, 32'd4,  32'd6, 1'b1, 1'b0},
    '{1'b1, 16'd1,  16'd2, 32'd2,  32'd3, 1'b1, 1'b0},
    '{1'b0, 16'd4,  16'd7, 32'd5,  32'd5, 1'b0, 1'b0},
    '{1'b1, 16'd12, 16'd2, 32'd13, 32'd3, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_reset(input logic dual, input logic dsel);
    @(negedge clk_i);
    rst_ni = 1'b0; step_i = 1'b0; dual_mode_i = dual; div_sel_i = dsel;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [15:0] val);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = val;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_irq(output int unsigned n);
    n = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk_i);
      n++;
      if (irq_o) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned n;

    // R1 reset state
    do_reset(1'b0, 1'b0);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 phase", 32'(phase_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // table-driven period / phase checks (R4, R5, R3)
    for (int i = 0; i < 4; i++) begin
      do_reset(VEC[i].dual, 1'b0);
      wr(1'b0, VEC[i].lim_a);
      wr(1'b1, VEC[i].lim_b);
      step_i = 1'b1;
      wait_irq(n);
      chk(VEC[i].dual ? "R4 first phase len" : "R5 period", n, VEC[i].len1);
      chk("R4 phase at first irq", 32'(phase_o), 32'(VEC[i].ph1));
      chk("R3 count zero at irq", 32'(count_o), 0);
      @(negedge clk_i);
      chk("R3 irq one cycle", 32'(irq_o), 0);
      wait_irq(n);
      chk(VEC[i].dual ? "R4 second phase len" : "R5 period", n + 1, VEC[i].len2);
      chk(VEC[i].dual ? "R4 phase at second irq" : "R5 phase stays A",
          32'(phase_o), 32'(VEC[i].ph2));
      step_i = 1'b0;
    end

    // R2 stepping only on enable
    do_reset(1'b0, 1'b0);
    wr(1'b0, 16'd1000);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk_i); step_i = 1'b1;
      @(negedge clk_i); step_i = 1'b0;
      repeat (2) @(negedge clk_i);
    end
    chk("R2 three pulses", 32'(count_o), 3);
    repeat (10) @(negedge clk_i);
    chk("R2 hold without step", 32'(count_o), 3);

    // R1 reset mid-run in B phase
    do_reset(1'b1, 1'b0);
    wr(1'b0, 16'd2); wr(1'b1, 16'd50);
    step_i = 1'b1;
    wait_irq(n);
    repeat (5) @(negedge clk_i);
    chk("R4 phase B mid-phase", 32'(phase_o), 1);
    chk("R4 count mid-phase", 32'(count_o), 5);
    do_reset(1'b1, 1'b0);
    chk("R1 count after reset", 32'(count_o), 0);
    chk("R1 phase after reset", 32'(phase_o), 0);

    // R7 write above current count takes effect at next comparison
    do_reset(1'b0, 1'b0);
    wr(1'b0, 16'd100);
    step_i = 1'b1;
    repeat (10) @(negedge clk_i);
    step_i = 1'b0;
    chk("R7 count before write", 32'(count_o), 10);
    wr(1'b0, 16'd30);
    step_i = 1'b1;
    wait_irq(n);
    chk("R7 new limit used", n, 21);

    // R7 write below current count wraps through FFFFh
    do_reset(1'b0, 1'b0);
    wr(1'b0, 16'd100);
    step_i = 1'b1;
    repeat (50) @(negedge clk_i);
    step_i = 1'b0;
    wr(1'b0, 16'd20);
    step_i = 1'b1;
    wait_irq(n);
    chk("R7 wrap before match", n, 65536 - 50 + 21);
    step_i = 1'b0;

    // R6 zero limit full range
    do_reset(1'b0, 1'b0);
    wr(1'b0, 16'd0);
    step_i = 1'b1;
    repeat (65535) @(negedge clk_i);
    chk("R6 count at top", 32'(count_o), 32'hFFFF);
    chk("R6 no irq before top", 32'(irq_o), 0);
    @(negedge clk_i);
    chk("R6 irq after 65536 steps", 32'(irq_o), 1);
    chk("R6 count wrapped", 32'(count_o), 0);
    step_i = 1'b0;

    // R8 internal divider
    do_reset(1'b0, 1'b1);
    wr(1'b0, 16'd9);
    step_i = 1'b1;
    wait_irq(n);
    wait_irq(n);
    chk("R8 divided period", n, 40);
    repeat (4) @(negedge clk_i);
    chk("R8 one step per four clocks", 32'(count_o), 1);
    step_i = 1'b0;
    repeat (12) @(negedge clk_i);
    chk("R8 enable low holds count", 32'(count_o), 1);

    finish_run();
  end
endmodule